// File: doc/BRIEF.md
# Wilkinson Converter Count-and-Latch Core

This block is the digital side of a many-channel ramp converter. An outside ramp generator and per-channel comparators turn each analog level into a time. The block measures that time by running one shared count and capturing its value, per channel, at the moment that channel's comparator trips. A counter-reset command clears every channel and starts a conversion. The count then advances once per cycle of `clk`, which runs at twice the back-end clock, so one `clk` cycle is one half back-end period. The count stops when it reaches a programmable limit, and every channel that has not tripped by then takes the limit as its code.

An optional pedestal-tracking mode holds the count at zero until a programmed number of channels have tripped. The channels that sit near the common baseline trip first, so the shared offset is removed from every code. A configuration bit selects which comparator transition counts as a trip. Comparator outputs arrive already synchronised to `clk`. The configuration inputs are held steady while a conversion runs.

Top module: `ramp_tdc_core`

## Requirements
- R1: While reset is asserted, and after it is released and before the first counter reset, `done_o` is 0 and every channel code is 0.
- R2: A `cnt_rst` pulse sampled on a clock edge sets every code to 0 and drops `done_o` from the next cycle on. It also restarts the shared count at 0 in that cycle.
- R3: With pedestal mode off, a channel whose trip is first sampled on the k-th clock edge after the edge that sampled `cnt_rst` captures the code k-1.
- R4: With `cfg_fall_edge`=0, a 0-to-1 comparator change is a trip and a 1-to-0 change is ignored. With `cfg_fall_edge`=1 the roles are swapped.
- R5: A channel captures at most once per conversion. Further comparator changes leave its code unchanged until the next `cnt_rst`.
- R6: The count never passes `cfg_modulo`. Once the count equals `cfg_modulo` and is not held, `done_o` rises on the next edge. With `cfg_modulo`=0 and pedestal mode off, `done_o` is 1 one cycle after the conversion starts.
- R7: When `done_o` rises, every channel that did not trip holds the code `cfg_modulo`.
- R8: With `cfg_ped_en`=1, the count stays at 0 while fewer than `cfg_ped_need` channels have captured. Channels that trip in that window capture 0. The count starts advancing in the cycle after the captured tally reaches `cfg_ped_need`. The tally saturates at its all-ones value.
- R9: After `done_o` rises, comparator changes alter neither the codes nor `done_o` until the next `cnt_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, twice the back-end clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cnt_rst | input | 1 | Counter-reset command: clears codes and starts a conversion |
| cfg_modulo | input | CW | Final count value of a conversion |
| cfg_fall_edge | input | 1 | 0: rising comparator change trips; 1: falling change trips |
| cfg_ped_en | input | 1 | Enables the pedestal-tracking start delay |
| cfg_ped_need | input | CW | Number of captured channels that releases the count |
| cmp_i | input | NCH | Synchronised comparator outputs, one bit per channel |
| code_o | output | NCH*CW | Captured codes; channel c occupies bits c*CW +: CW |
| done_o | output | 1 | Conversion finished; codes are final |

## Verification
A count that drifts or fails to stop shows up in every code captured after the fault, and `done_o` rises early or late against the cycle the bench computes from `cfg_modulo`. A wrong edge detector or a capture flag that fails to clear shows up in the first conversion that exercises it. The affected channel either keeps a stale code from the previous conversion or reports a code from a later trip. An error in the pedestal tally shifts every code captured after the release point by the same number of cycles. That shift appears at the ports as soon as the conversion completes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_RUN  = 2'd1,
    CS_DONE = 2'd2
  } conv_state_e;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          hold,
  input  logic [CW-1:0] modulo,
  output logic [CW-1:0] count_o,
  output logic          run_o,
  output logic          finish_o,
  output logic          done_o
);
  import rtc_pkg::*;

  conv_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_top;

  assign at_top   = (cnt_q == modulo);
  assign run_o    = (state_q == CS_RUN);
  assign finish_o = run_o && !hold && at_top && !start;
  assign done_o   = (state_q == CS_DONE);

  // next-state and count enable
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (start) begin
      state_d = CS_RUN;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else if (run_o && !hold) begin
      if (at_top) begin
        state_d = CS_DONE;
      end else begin
        cnt_d  = cnt_q + 1'b1;
        cnt_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_o |-> (cnt_q <= modulo));

  p_done_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    finish_o |=> done_o);

  p_hold_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && hold && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_channel.sv
module rtc_channel #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          run,
  input  logic          finish,
  input  logic          fall_sel,
  input  logic          cmp_i,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] code_o,
  output logic          latched_o
);
  logic          cmp_q;
  logic          rise_ev, fall_ev, trip;
  logic          capture;
  logic [CW-1:0] code_q, code_d;
  logic          lat_q, lat_d;
  logic          code_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= 1'b0;
    else        cmp_q <= cmp_i;
  end

  assign rise_ev = cmp_i & ~cmp_q;
  assign fall_ev = ~cmp_i & cmp_q;
  assign trip    = fall_sel ? fall_ev : rise_ev;
  assign capture = run & ~lat_q & (trip | finish) & ~start;

  always_comb begin
    code_d  = code_q;
    lat_d   = lat_q;
    code_en = 1'b0;
    if (start) begin
      code_d  = '0;
      lat_d   = 1'b0;
      code_en = 1'b1;
    end else if (capture) begin
      code_d  = count;
      lat_d   = 1'b1;
      code_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      lat_q  <= 1'b0;
    end else if (code_en) begin
      code_q <= code_d;
      lat_q  <= lat_d;
    end
  end

  assign code_o    = code_q;
  assign latched_o = lat_q;

  p_latch_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !start) |=> ($stable(code_q) && lat_q));

  p_clear_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((code_q == '0) && !lat_q));
endmodule

// File: rtl/rtc_popcnt.sv
module rtc_popcnt #(
  parameter int NCH = 128,
  parameter int CW  = 8
) (
  input  logic [NCH-1:0] bits_i,
  output logic [CW-1:0]  tally_o
);
  localparam int unsigned MAXV = (32'd1 << CW) - 32'd1;

  int unsigned total;

  always_comb begin
    total = 0;
    for (int i = 0; i < NCH; i++) begin
      total += 32'(bits_i[i]);
    end
    tally_o = (total > MAXV) ? CW'(MAXV) : CW'(total);
  end
endmodule

// File: rtl/ramp_tdc_core.sv
module ramp_tdc_core #(
  parameter int NCH = 128,
  parameter int CW  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_rst,
  input  logic [CW-1:0]     cfg_modulo,
  input  logic              cfg_fall_edge,
  input  logic              cfg_ped_en,
  input  logic [CW-1:0]     cfg_ped_need,
  input  logic [NCH-1:0]    cmp_i,
  output logic [NCH*CW-1:0] code_o,
  output logic              done_o
);
  logic           rst_i_n;
  logic [CW-1:0]  count;
  logic           run, finish;
  logic           hold;
  logic [NCH-1:0] latched;
  logic [CW-1:0]  tally;

  rtc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  rtc_popcnt #(.NCH(NCH), .CW(CW)) u_tally (
    .bits_i  (latched),
    .tally_o (tally)
  );

  assign hold = cfg_ped_en && (tally < cfg_ped_need);

  rtc_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .start    (cnt_rst),
    .hold     (hold),
    .modulo   (cfg_modulo),
    .count_o  (count),
    .run_o    (run),
    .finish_o (finish),
    .done_o   (done_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    rtc_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_i_n),
      .start     (cnt_rst),
      .run       (run),
      .finish    (finish),
      .fall_sel  (cfg_fall_edge),
      .cmp_i     (cmp_i[g]),
      .count     (count),
      .code_o    (code_o[g*CW +: CW]),
      .latched_o (latched[g])
    );
  end

  p_unfired_filled_r7: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_o |-> (&latched));

  p_done_frozen_r9: assert property (@(posedge clk) disable iff (!rst_i_n)
    (done_o && !cnt_rst) |=> (done_o && $stable(code_o)));
endmodule

// File: tb/ramp_tdc_core_tb.sv
module ramp_tdc_core_tb;
  localparam int NCH = 128;
  localparam int CW  = 8;

  logic              clk;
  logic              rst_n;
  logic              cnt_rst;
  logic [CW-1:0]     cfg_modulo;
  logic              cfg_fall_edge;
  logic              cfg_ped_en;
  logic [CW-1:0]     cfg_ped_need;
  logic [NCH-1:0]    cmp;
  logic [NCH*CW-1:0] code;
  logic              done;

  int n_chk;
  int n_bad;
  bit finished;

  ramp_tdc_core #(.NCH(NCH), .CW(CW)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cnt_rst       (cnt_rst),
    .cfg_modulo    (cfg_modulo),
    .cfg_fall_edge (cfg_fall_edge),
    .cfg_ped_en    (cfg_ped_en),
    .cfg_ped_need  (cfg_ped_need),
    .cmp_i         (cmp),
    .code_o        (code),
    .done_o        (done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int code_of(input int ch);
    return int'(code[ch*CW +: CW]);
  endfunction

  task automatic chk(input int act, input int exp, input string rq, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns at the falling edge after the edge that sampled cnt_rst (count = 0)
  task automatic start_conv(input logic [CW-1:0] m, input logic fe, input logic pe,
                            input logic [CW-1:0] nd, input logic [NCH-1:0] idle);
    @(negedge clk);
    cfg_modulo = m; cfg_fall_edge = fe; cfg_ped_en = pe; cfg_ped_need = nd;
    cmp = idle;
    @(negedge clk);
    cnt_rst = 1'b1;
    @(negedge clk);
    cnt_rst = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cnt_rst = 1'b0; cmp = '0;
    cfg_modulo = 8'd0; cfg_fall_edge = 1'b0; cfg_ped_en = 1'b0; cfg_ped_need = 8'd0;
    step(4);
    chk(int'(done), 0, "R1", "done during reset");
    rst_n = 1'b1;
    step(4);
    chk(int'(done), 0, "R1", "done after reset");
    chk(code_of(0), 0, "R1", "code ch0 after reset");
    chk(code_of(127), 0, "R1", "code ch127 after reset");
  endtask

  task automatic t_rise_basic();
    logic [NCH-1:0] idle;
    idle = '0; idle[9] = 1'b1;
    start_conv(8'd20, 1'b0, 1'b0, 8'd0, idle);
    chk(int'(done), 0, "R2", "done after start");
    cmp[0] = 1'b1;                          // trip sampled on edge 1 -> code 0
    step(3); cmp[5] = 1'b1; cmp[9] = 1'b0;  // ch9 falls: ignored in rising mode
    step(3); cmp[5] = 1'b0; cmp[9] = 1'b1;  // ch9 rises -> code 6
    step(2); cmp[5] = 1'b1;                 // second trip on ch5 ignored
    step(2); cmp[100] = 1'b1;               // code 10
    step(10);
    chk(int'(done), 0, "R6", "done while count equals modulo");
    step(1);
    chk(int'(done), 1, "R6", "done one edge after reaching modulo");
    chk(code_of(0), 0, "R3", "ch0 code");
    chk(code_of(5), 3, "R5", "ch5 keeps first capture");
    chk(code_of(9), 6, "R4", "ch9 rising after ignored fall");
    chk(code_of(100), 10, "R3", "ch100 code");
    chk(code_of(1), 20, "R7", "unfired ch1 code");
    chk(code_of(127), 20, "R7", "unfired ch127 code");
  endtask

  task automatic t_after_done();
    cmp[1] = 1'b1; step(2);
    cmp[1] = 1'b0; step(2);
    cmp[1] = 1'b1; step(2);
    chk(code_of(1), 20, "R9", "ch1 after toggles past done");
    chk(int'(done), 1, "R9", "done stays high");
  endtask

  task automatic t_fall_mode();
    logic [NCH-1:0] idle;
    idle = '1; idle[11] = 1'b0;
    start_conv(8'd15, 1'b1, 1'b0, 8'd0, idle);
    chk(int'(done), 0, "R2", "done cleared by restart");
    chk(code_of(5), 0, "R2", "ch5 code cleared by restart");
    step(2); cmp[7] = 1'b0;                 // fall -> code 2
    step(1); cmp[11] = 1'b1;                // rise ignored in falling mode
    step(2); cmp[11] = 1'b0;                // fall -> code 5
    step(10);
    chk(int'(done), 0, "R6", "falling mode done not early");
    step(1);
    chk(int'(done), 1, "R6", "falling mode done");
    chk(code_of(7), 2, "R4", "ch7 falling trip");
    chk(code_of(11), 5, "R4", "ch11 rise ignored then fall");
    chk(code_of(0), 15, "R7", "ch0 unfired in falling mode");
  endtask

  task automatic t_pedestal();
    start_conv(8'd10, 1'b0, 1'b1, 8'd3, '0);
    step(1); cmp[10] = 1'b1;
    step(1); cmp[11] = 1'b1;
    step(2); cmp[12] = 1'b1;                // third capture releases the count
    step(1); cmp[13] = 1'b1;                // sampled while count still 0
    step(2); cmp[14] = 1'b1;                // count 2 when sampled
    step(8);
    chk(int'(done), 0, "R8", "held conversion not done early");
    step(1);
    chk(int'(done), 1, "R8", "held conversion done");
    chk(code_of(10), 0, "R8", "ch10 captured during hold");
    chk(code_of(11), 0, "R8", "ch11 captured during hold");
    chk(code_of(12), 0, "R8", "ch12 releasing capture");
    chk(code_of(13), 0, "R8", "ch13 first cycle after release");
    chk(code_of(14), 2, "R8", "ch14 after release");
    chk(code_of(0), 10, "R7", "ch0 unfired with pedestal mode");
  endtask

  task automatic t_mod_zero();
    start_conv(8'd0, 1'b0, 1'b0, 8'd0, '0);
    chk(int'(done), 0, "R6", "modulo zero, right after start");
    step(1);
    chk(int'(done), 1, "R6", "modulo zero done after one edge");
    chk(code_of(3), 0, "R7", "modulo zero unfired code");
  endtask

  initial begin
    n_chk = 0; n_bad = 0; finished = 1'b0;
    t_reset();
    t_rise_basic();
    t_after_done();
    t_fall_mode();
    t_pedestal();
    t_mod_zero();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500us;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule